// File: doc/BRIEF.md
# Prioritized Frame Transmit Queue

This block collects the frames that a peripheral wants to send to its host and feeds them one at a time onto an 8-bit valid/ready byte stream. It has three fixed slots. The not-ready slot holds a short flow-control frame. The status slot holds a short interrupt-status frame. The data slot holds one large response frame. Each slot has its own load port. A frame loaded into one slot waits independently of the others, so a flow-control notice, an exceptional-condition report and a pending response can all be queued at once without any of them blocking the rest.

On the wire, each frame is a flag byte (0x7E), then the body with transparency escaping, then another flag byte. A level-sensitive `irq` output reports data pending. It rises once any slot holds a frame. It falls only after the closing flag of the last queued frame has been accepted downstream. The host can therefore read until the line drops.

Software fills the data slot byte by byte at any index and then commits it with a length. The two short slots load in one cycle from a packed byte vector. A load aimed at a slot that is still occupied is refused and reported on `busy`.

Top module: `prio_frame_txq`

## Requirements
- R1: `irq` is high in the cycle after any load or commit that the slot accepts.
- R2: `irq` stays high while any slot is occupied. It goes low in the cycle after the closing flag of the last occupied slot is accepted, and only then.
- R3: Every frame is sent as 0x7E, the escaped body bytes in index order, then 0x7E. A frame of length zero is sent as two flag bytes.
- R4: A body byte equal to 0x7E or 0x7D is sent as 0x7D followed by the byte XOR 0x20. Every other body byte is sent unchanged.
- R5: When the stream is idle and several slots are occupied, the not-ready frame is sent first, then the status frame, then the data frame.
- R6: Once a frame has started, it is sent to its closing flag before any other frame starts, even if a slot of higher priority is loaded meanwhile.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values. A slot is emptied only when its closing flag is accepted.
- R8: A load, byte write or commit to an occupied slot is refused and leaves that slot's contents unchanged. In the same cycle it raises the slot's `busy` bit: bit 0 for not-ready, bit 1 for status, bit 2 for data.
- R9: A commit or load whose length exceeds the slot's capacity is refused and raises that slot's `busy` bit. Nothing is queued and `irq` stays low.
- R10: The data slot holds a frame of up to DATA_MAX bytes (514 by default: 512 payload plus address and control). All three slots can be occupied at the same time.
- R11: After reset, `tx_valid`, `irq` and `busy` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dat_wr_en | input | 1 | Write one byte into the data slot buffer |
| dat_wr_idx | input | DIDX_W (10) | Byte index for the data slot write |
| dat_wr_byte | input | 8 | Byte value to write |
| dat_commit | input | 1 | Mark the data slot occupied with length `dat_len` |
| dat_len | input | DLEN_W (10) | Data frame length in bytes |
| ist_load | input | 1 | Load the status slot |
| ist_len | input | SLEN_W (3) | Status frame length |
| ist_bytes | input | SMALL_MAX*8 (32) | Status frame bytes, byte 0 in bits 7:0 |
| rnr_load | input | 1 | Load the not-ready slot |
| rnr_len | input | SLEN_W (3) | Not-ready frame length |
| rnr_bytes | input | SMALL_MAX*8 (32) | Not-ready frame bytes, byte 0 in bits 7:0 |
| tx_valid | output | 1 | Output byte is valid |
| tx_data | output | 8 | Output byte |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Data pending to the host |
| busy | output | 3 | Per-slot rejection flag for this cycle's write attempt |

## Verification
Several properties are checked on every cycle. While a byte is stalled, the stream holds its value. No raw flag byte appears inside a body. The frame being sent never changes mid-frame. An occupied not-ready slot wins arbitration. `irq` can only fall right after a closing flag was accepted. An occupied slot keeps its contents until it is drained. The exact byte sequence of each frame, the ordering across slots, the refusal of oversized or colliding loads, and the rise of `irq` after a load can only be shown by the bench. It does so by comparing the captured stream against frames it encodes itself, under random back-pressure and random content heavy in 0x7E and 0x7D.

// File: rtl/txq_pkg.sv
package txq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_BODY,
        ST_ESC,
        ST_CLOSE
    } txq_state_e;

    localparam logic [7:0] FLAG_BYTE = 8'h7E;
    localparam logic [7:0] ESC_BYTE  = 8'h7D;
    localparam logic [7:0] ESC_XOR   = 8'h20;

    localparam int NSLOT    = 3;
    localparam int SLOT_RNR = 0;
    localparam int SLOT_IST = 1;
    localparam int SLOT_DAT = 2;
endpackage

// File: rtl/txq_ctl_slot.sv
module txq_ctl_slot #(
    parameter int MAXB  = 4,
    parameter int LEN_W = 3,
    parameter int IDX_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [LEN_W-1:0]    ld_len,
    input  logic [MAXB*8-1:0]   ld_bytes,
    input  logic                clr,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic                valid,
    output logic [IDX_W-1:0]    len_o,
    output logic [7:0]          rd_byte,
    output logic                reject
);
    typedef struct packed {
        logic              valid;
        logic [LEN_W-1:0]  len;
        logic [MAXB*8-1:0] bytes;
    } slot_t;

    slot_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        reject = load && (s_q.valid || (ld_len > LEN_W'(MAXB)));
        if (clr) begin
            s_d.valid = 1'b0;
        end
        if (load && !reject) begin
            s_d.valid = 1'b1;
            s_d.len   = ld_len;
            s_d.bytes = ld_bytes;
        end
        rd_byte = '0;
        for (int k = 0; k < MAXB; k++) begin
            if (rd_idx == IDX_W'(k)) rd_byte = s_q.bytes[k*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.valid;
    assign len_o = IDX_W'(s_q.len);

    // A queued frame keeps its contents until drained
    assert_slot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.valid && !clr) |=> (s_q.valid && $stable(s_q.len) && $stable(s_q.bytes)));
endmodule

// File: rtl/txq_data_buf.sv
module txq_data_buf #(
    parameter int DEPTH = 514,
    parameter int IDX_W = 10,
    parameter int LEN_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [7:0]        wr_byte,
    input  logic              commit,
    input  logic [LEN_W-1:0]  c_len,
    input  logic              clr,
    input  logic [LEN_W-1:0]  rd_idx,
    output logic              valid,
    output logic [LEN_W-1:0]  len_o,
    output logic [7:0]        rd_byte,
    output logic              reject
);
    typedef struct packed {
        logic             valid;
        logic [LEN_W-1:0] len;
    } dctl_t;

    dctl_t c_d, c_q;
    logic [7:0] mem [DEPTH];
    logic       wr_ok;

    always_comb begin
        c_d    = c_q;
        reject = ((wr_en || commit) && c_q.valid) ||
                 (commit && (c_len > LEN_W'(DEPTH)));
        wr_ok  = wr_en && !c_q.valid &&
                 ({1'b0, wr_idx} < (IDX_W+1)'(DEPTH));
        if (clr) begin
            c_d.valid = 1'b0;
        end
        if (commit && !reject) begin
            c_d.valid = 1'b1;
            c_d.len   = c_len;
        end
        if (rd_idx < LEN_W'(DEPTH)) rd_byte = mem[rd_idx[IDX_W-1:0]];
        else                        rd_byte = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_idx] <= wr_byte;
    end

    assign valid = c_q.valid;
    assign len_o = c_q.len;

    // Committed data frame stays until its closing flag is accepted
    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.valid && !clr) |=> (c_q.valid && $stable(c_q.len)));
endmodule

// File: rtl/txq_prio_pick.sv
module txq_prio_pick #(
    parameter int N = 3,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req,
    output logic [W-1:0] gnt,
    output logic         any
);
    always_comb begin
        gnt = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) gnt = W'(k);
        end
        any = |req;
    end
endmodule

// File: rtl/prio_frame_txq.sv
module prio_frame_txq
    import txq_pkg::*;
#(
    parameter int DATA_MAX  = 514,
    parameter int SMALL_MAX = 4,
    localparam int DIDX_W = $clog2(DATA_MAX),
    localparam int DLEN_W = $clog2(DATA_MAX + 1),
    localparam int SLEN_W = $clog2(SMALL_MAX + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   dat_wr_en,
    input  logic [DIDX_W-1:0]      dat_wr_idx,
    input  logic [7:0]             dat_wr_byte,
    input  logic                   dat_commit,
    input  logic [DLEN_W-1:0]      dat_len,
    input  logic                   ist_load,
    input  logic [SLEN_W-1:0]      ist_len,
    input  logic [SMALL_MAX*8-1:0] ist_bytes,
    input  logic                   rnr_load,
    input  logic [SLEN_W-1:0]      rnr_len,
    input  logic [SMALL_MAX*8-1:0] rnr_bytes,
    output logic                   tx_valid,
    output logic [7:0]             tx_data,
    input  logic                   tx_ready,
    output logic                   irq,
    output logic [2:0]             busy
);
    typedef struct packed {
        txq_state_e        st;
        logic [1:0]        sel;
        logic [DLEN_W-1:0] idx;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [NSLOT-1:0]  slot_vld;
    logic [NSLOT-1:0]  slot_clr;
    logic [DLEN_W-1:0] slot_len  [NSLOT];
    logic [7:0]        slot_byte [NSLOT];
    logic [1:0]        gnt;
    logic              any_req;
    logic [7:0]        cur_byte;
    logic [DLEN_W-1:0] cur_len;
    logic [DLEN_W-1:0] nxt_idx;
    logic              need_esc;
    logic              accept;

    logic [1:0]              sm_load;
    logic [SLEN_W-1:0]       sm_len   [2];
    logic [SMALL_MAX*8-1:0]  sm_bytes [2];

    assign sm_load     = {ist_load, rnr_load};
    assign sm_len[0]   = rnr_len;
    assign sm_len[1]   = ist_len;
    assign sm_bytes[0] = rnr_bytes;
    assign sm_bytes[1] = ist_bytes;

    // short control slots: index 0 = not-ready, index 1 = status
    for (genvar g = 0; g < 2; g++) begin : g_small
        txq_ctl_slot #(
            .MAXB  (SMALL_MAX),
            .LEN_W (SLEN_W),
            .IDX_W (DLEN_W)
        ) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (sm_load[g]),
            .ld_len   (sm_len[g]),
            .ld_bytes (sm_bytes[g]),
            .clr      (slot_clr[g]),
            .rd_idx   (f_q.idx),
            .valid    (slot_vld[g]),
            .len_o    (slot_len[g]),
            .rd_byte  (slot_byte[g]),
            .reject   (busy[g])
        );
    end

    txq_data_buf #(
        .DEPTH (DATA_MAX),
        .IDX_W (DIDX_W),
        .LEN_W (DLEN_W)
    ) i_dbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dat_wr_en),
        .wr_idx  (dat_wr_idx),
        .wr_byte (dat_wr_byte),
        .commit  (dat_commit),
        .c_len   (dat_len),
        .clr     (slot_clr[SLOT_DAT]),
        .rd_idx  (f_q.idx),
        .valid   (slot_vld[SLOT_DAT]),
        .len_o   (slot_len[SLOT_DAT]),
        .rd_byte (slot_byte[SLOT_DAT]),
        .reject  (busy[SLOT_DAT])
    );

    txq_prio_pick #(.N(NSLOT)) i_pick (
        .req (slot_vld),
        .gnt (gnt),
        .any (any_req)
    );

    always_comb begin
        case (f_q.sel)
            2'(SLOT_RNR): begin cur_byte = slot_byte[SLOT_RNR]; cur_len = slot_len[SLOT_RNR]; end
            2'(SLOT_IST): begin cur_byte = slot_byte[SLOT_IST]; cur_len = slot_len[SLOT_IST]; end
            default:      begin cur_byte = slot_byte[SLOT_DAT]; cur_len = slot_len[SLOT_DAT]; end
        endcase
    end

    always_comb begin
        f_d      = f_q;
        slot_clr = '0;
        need_esc = (cur_byte == FLAG_BYTE) || (cur_byte == ESC_BYTE);
        nxt_idx  = f_q.idx + 1'b1;
        tx_valid = (f_q.st != ST_IDLE);
        tx_data  = FLAG_BYTE;
        accept   = tx_valid && tx_ready;
        case (f_q.st)
            ST_IDLE: begin
                if (any_req) begin
                    f_d.st  = ST_OPEN;
                    f_d.sel = gnt;
                    f_d.idx = '0;
                end
            end
            ST_OPEN: begin
                if (accept) f_d.st = (cur_len == '0) ? ST_CLOSE : ST_BODY;
            end
            ST_BODY: begin
                tx_data = need_esc ? ESC_BYTE : cur_byte;
                if (accept) begin
                    if (need_esc) begin
                        f_d.st = ST_ESC;
                    end else begin
                        f_d.idx = nxt_idx;
                        f_d.st  = (nxt_idx == cur_len) ? ST_CLOSE : ST_BODY;
                    end
                end
            end
            ST_ESC: begin
                tx_data = cur_byte ^ ESC_XOR;
                if (accept) begin
                    f_d.idx = nxt_idx;
                    f_d.st  = (nxt_idx == cur_len) ? ST_CLOSE : ST_BODY;
                end
            end
            ST_CLOSE: begin
                if (accept) begin
                    slot_clr[f_q.sel] = 1'b1;
                    f_d.st            = ST_IDLE;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, sel: '0, idx: '0};
        else        f_q <= f_d;
    end

    assign irq = |slot_vld;

    assert_irq_while_sending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> irq);

    assert_irq_falls_on_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(f_q.st == ST_CLOSE && tx_ready));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    assert_no_raw_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_BODY || f_q.st == ST_ESC) |-> (tx_data != FLAG_BYTE));

    assert_no_preempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st != ST_IDLE && $past(f_q.st != ST_IDLE)) |-> (f_q.sel == $past(f_q.sel)));

    assert_rnr_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.st == ST_IDLE && slot_vld[SLOT_RNR]) |=>
            (f_q.st == ST_OPEN && f_q.sel == 2'(SLOT_RNR)));
endmodule

// File: tb/test_prio_frame_txq.sv
`timescale 1ns/1ps
module test_prio_frame_txq;
    localparam int DMAX = 514;
    localparam int SMAX = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dat_wr_en = 1'b0;
    logic [9:0]  dat_wr_idx = '0;
    logic [7:0]  dat_wr_byte = '0;
    logic        dat_commit = 1'b0;
    logic [9:0]  dat_len = '0;
    logic        ist_load = 1'b0;
    logic [2:0]  ist_len = '0;
    logic [31:0] ist_bytes = '0;
    logic        rnr_load = 1'b0;
    logic [2:0]  rnr_len = '0;
    logic [31:0] rnr_bytes = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        irq;
    logic [2:0]  busy;

    prio_frame_txq i_prio_frame_txq (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int pend = 0, flag_cnt = 0, irq_err = 0;
    int rdy_mode = 0;
    logic [7:0] got[$];
    logic [7:0] expq[$];
    logic [7:0] dbuf [DMAX];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    // ready driver and stream collector, sampling 1ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0:       tx_ready = ($urandom % 4) != 0;
                1:       tx_ready = 1'b1;
                default: tx_ready = 1'b0;
            endcase
            #1;
            if (rst_n) begin
                if (irq !== (pend > 0)) irq_err++;
                if (tx_valid && tx_ready) begin
                    got.push_back(tx_data);
                    if (tx_data == 8'h7E) begin
                        flag_cnt++;
                        if (flag_cnt % 2 == 0) pend--;
                    end
                end
            end
        end
    end

    function automatic logic [7:0] rnd_byte();
        int r = $urandom % 4;
        if (r == 0) return 8'h7E;
        if (r == 1) return 8'h7D;
        return 8'($urandom);
    endfunction

    task automatic push_stuffed(input logic [7:0] b);
        if (b == 8'h7E || b == 8'h7D) begin
            expq.push_back(8'h7D);
            expq.push_back(b ^ 8'h20);
        end else begin
            expq.push_back(b);
        end
    endtask

    task automatic exp_data(input int len);
        expq.push_back(8'h7E);
        for (int i = 0; i < len; i++) push_stuffed(dbuf[i]);
        expq.push_back(8'h7E);
    endtask

    task automatic exp_small(input logic [31:0] b, input int len);
        expq.push_back(8'h7E);
        for (int i = 0; i < len; i++) push_stuffed(b[i*8 +: 8]);
        expq.push_back(8'h7E);
    endtask

    task automatic cmp_stream(input string req, input string what);
        int bad_at = -1;
        logic [7:0] a = 0, e = 0;
        for (int i = 0; i < expq.size() && i < got.size(); i++) begin
            if (bad_at < 0 && got[i] !== expq[i]) begin
                bad_at = i; a = got[i]; e = expq[i];
            end
        end
        if (bad_at >= 0)
            chk(0, req, $sformatf("%s byte %0d", what, bad_at), a, e);
        else
            chk(got.size() == expq.size(), req, {what, " length"}, got.size(), expq.size());
        got.delete();
        expq.delete();
    endtask

    task automatic write_dbytes(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            dat_wr_en = 1'b1; dat_wr_idx = 10'(i); dat_wr_byte = dbuf[i];
        end
        @(negedge clk);
        dat_wr_en = 1'b0;
    endtask

    task automatic fire(input bit d, input bit s, input bit r,
                        input int dl, input int sl, input int rl);
        @(negedge clk);
        dat_commit = d; dat_len = 10'(dl);
        ist_load = s; ist_len = 3'(sl);
        rnr_load = r; rnr_len = 3'(rl);
        @(posedge clk);
        pend += int'(d) + int'(s) + int'(r);
        @(negedge clk);
        dat_commit = 1'b0; ist_load = 1'b0; rnr_load = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        bit ok = 0;
        for (int t = 0; t < 20000; t++) begin
            @(negedge clk); #2;
            if (pend == 0 && !tx_valid) begin ok = 1; break; end
        end
        chk(ok, req, "drain", pend, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic irq_ok(input string req);
        chk(irq_err == 0, req, "irq vs pending count", irq_err, 0);
        irq_err = 0;
    endtask

    initial begin
        logic [7:0] cap;
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R11 reset state
        chk(tx_valid == 1'b0, "R11", "tx_valid after reset", tx_valid, 0);
        chk(irq == 1'b0, "R11", "irq after reset", irq, 0);
        chk(busy == 3'b000, "R11", "busy after reset", busy, 0);

        // R3 R4 R1: single data frame
        for (int i = 0; i < 24; i++) dbuf[i] = rnd_byte();
        write_dbytes(24);
        fire(1, 0, 0, 24, 0, 0);
        #1;
        chk(irq == 1'b1, "R1", "irq after commit", irq, 1);
        exp_data(24);
        wait_idle("R2");
        cmp_stream("R4", "single data frame");
        irq_ok("R2");

        // R3: zero-length status frame
        ist_bytes = 32'h7E7D7E7D;
        fire(0, 1, 0, 0, 0, 0);
        exp_small(ist_bytes, 0);
        wait_idle("R3");
        cmp_stream("R3", "empty frame");

        // R5 R10: all three at once, then a colliding status load (R8)
        for (int i = 0; i < 10; i++) dbuf[i] = rnd_byte();
        write_dbytes(10);
        ist_bytes = 32'h11_7E_22_33;
        rnr_bytes = 32'h00_00_7D_81;
        rdy_mode = 2;
        fire(1, 1, 1, 10, 4, 2);
        @(negedge clk);
        ist_load = 1'b1; ist_len = 3'd1; ist_bytes = 32'hAA;
        #1;
        chk(busy == 3'b010, "R8", "status load while occupied", busy, 3'b010);
        @(negedge clk);
        ist_load = 1'b0; ist_bytes = 32'h11_7E_22_33;
        rdy_mode = 0;
        exp_small(32'h00_00_7D_81, 2);
        exp_small(32'h11_7E_22_33, 4);
        exp_data(10);
        wait_idle("R10");
        cmp_stream("R5", "priority order");
        irq_ok("R2");

        // R6 R8: no preemption, writes into a sending data slot refused
        for (int i = 0; i < 40; i++) dbuf[i] = rnd_byte();
        write_dbytes(40);
        fire(1, 0, 0, 40, 0, 0);
        for (int t = 0; t < 100 && !tx_valid; t++) @(negedge clk);
        repeat (4) @(negedge clk);
        rnr_bytes = 32'h0000_0042;
        fire(0, 0, 1, 0, 0, 1);
        @(negedge clk);
        dat_wr_en = 1'b1; dat_wr_idx = 10'd30; dat_wr_byte = ~dbuf[30];
        #1;
        chk(busy == 3'b100, "R8", "byte write while sending", busy, 3'b100);
        @(negedge clk);
        dat_wr_en = 1'b0; dat_commit = 1'b1; dat_len = 10'd3;
        #1;
        chk(busy == 3'b100, "R8", "commit while sending", busy, 3'b100);
        @(negedge clk);
        dat_commit = 1'b0;
        exp_data(40);
        exp_small(32'h42, 1);
        wait_idle("R6");
        cmp_stream("R6", "in-flight frame finishes first");
        irq_ok("R2");

        // R9: oversized lengths refused
        @(negedge clk);
        ist_load = 1'b1; ist_len = 3'(SMAX + 1);
        #1;
        chk(busy == 3'b010, "R9", "oversized status load", busy, 3'b010);
        @(negedge clk);
        ist_load = 1'b0; dat_commit = 1'b1; dat_len = 10'(DMAX + 1);
        #1;
        chk(busy == 3'b100, "R9", "oversized data commit", busy, 3'b100);
        @(negedge clk);
        dat_commit = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk(irq == 1'b0 && tx_valid == 1'b0, "R9", "nothing queued", {irq, tx_valid}, 0);

        // R7: stalled byte holds
        for (int i = 0; i < 10; i++) dbuf[i] = 8'(i + 1);
        write_dbytes(10);
        rdy_mode = 2;
        fire(1, 0, 0, 10, 0, 0);
        for (int t = 0; t < 20 && !tx_valid; t++) @(negedge clk);
        #1;
        cap = tx_data;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk); #1;
            chk(tx_valid && tx_data == cap, "R7", "stalled byte", tx_data, cap);
        end
        rdy_mode = 0;
        exp_data(10);
        wait_idle("R7");
        cmp_stream("R7", "frame after stall");

        // R10 R4: full-size data frame of special bytes
        for (int i = 0; i < DMAX; i++) dbuf[i] = (i % 3 == 0) ? 8'h7D : ((i % 3 == 1) ? 8'h7E : 8'(i));
        write_dbytes(DMAX);
        rdy_mode = 1;
        fire(1, 0, 0, DMAX, 0, 0);
        exp_data(DMAX);
        wait_idle("R10");
        cmp_stream("R10", "full-size frame");
        irq_ok("R2");

        // random mixes
        for (int it = 0; it < 20; it++) begin
            int m = 1 + ($urandom % 7);
            int dl = $urandom % 48;
            int sl = $urandom % (SMAX + 1);
            int rl = $urandom % (SMAX + 1);
            rdy_mode = $urandom % 2;
            if (m[2]) begin
                for (int i = 0; i < dl; i++) dbuf[i] = rnd_byte();
                write_dbytes(dl);
            end
            ist_bytes = {rnd_byte(), rnd_byte(), rnd_byte(), rnd_byte()};
            rnr_bytes = {rnd_byte(), rnd_byte(), rnd_byte(), rnd_byte()};
            fire(m[2], m[1], m[0], dl, sl, rl);
            if (m[0]) exp_small(rnr_bytes, rl);
            if (m[1]) exp_small(ist_bytes, sl);
            if (m[2]) exp_data(dl);
            wait_idle("R2");
            cmp_stream("R5", $sformatf("random mix %0d", it));
        end
        irq_ok("R2");

        summary();
        $finish;
    end
endmodule